// File: doc/BRIEF.md
# Windowed I/O Port Address Translator

This block sits between a big-endian processor bus and a little-endian legacy I/O port space. A request whose address lands in an 8 MB aperture at `0x8000_0000` becomes one I/O read or write strobe. The block forms a 16-bit port number from the address and reorders the data bytes so that the processor's multi-byte values arrive at the devices in their native byte order. Requests outside the aperture are dropped and raise no strobe.

Port numbers can be formed in two ways, selected per request by a mode bit. In the dense mode the aperture folds onto a flat 64 KB port space. In the sparse mode each 4 KB page of the aperture reaches only 32 consecutive ports. The page index then supplies the upper port bits, so devices can be protected at page granularity. The mode bit is captured together with the request. A request is registered onto the I/O side one cycle after it is presented. Read data from the device is byte-corrected and returned one cycle after the read strobe.

Top module: `io_window_bridge`

## Requirements
- R1: A request is forwarded only when cpu_addr[31:23] equals 9'h100, which is the window 0x8000_0000 to 0x807F_FFFF. For any other address, neither io_rd nor io_wr rises and no read data is returned.
- R2: With map_sparse at 0 when the request is presented, io_addr equals cpu_addr[15:0].
- R3: With map_sparse at 1 when the request is presented, io_addr equals {cpu_addr[22:12], cpu_addr[4:0]}. Port bits 15:5 carry the page index and bits 4:0 carry the offset within the page.
- R4: Size code 0 (byte) and the reserved code 3 pass the data through unchanged in both directions.
- R5: Size code 1 (16-bit) gives {16'h0000, d[7:0], d[15:8]} in both directions.
- R6: Size code 2 (32-bit) reverses all four bytes, giving {d[7:0], d[15:8], d[23:16], d[31:24]}, in both directions.
- R7: A forwarded request raises io_wr (cpu_we=1) or io_rd (cpu_we=0) for exactly one cycle, in the cycle after the request edge. io_addr, io_size and io_wdata are valid in that same cycle, and the two strobes are never high together.
- R8: One cycle after io_rd, cpu_rvalid pulses for one cycle. cpu_rdata then holds io_rdata as sampled during the strobe, lane-corrected with the size of that access.
- R9: map_sparse is sampled only at the request edge. Changing it afterwards does not alter the port address or the read data of that access.
- R10: While rst_n is low and just after release, io_rd, io_wr and cpu_rvalid are 0, and io_addr, io_wdata and cpu_rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | One-cycle request pulse |
| cpu_addr | input | 32 | Processor bus address |
| cpu_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 treated as byte |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_wdata | input | 32 | Write data, processor byte order |
| map_sparse | input | 1 | Port mapping mode: 0 dense, 1 sparse |
| io_rdata | input | 32 | Read data from the device, device byte order |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_addr | output | 16 | I/O port address |
| io_size | output | 2 | Access size passed to the device |
| io_wdata | output | 32 | Lane-corrected write data |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cpu_rdata | output | 32 | Lane-corrected read data |

## Verification
The bench probes addresses on both sides of each aperture edge, because a comparator that is off by one bit would forward a request just outside the window or drop its last byte. It also uses sparse addresses in which bits 11:5 are set and the page index is at its maximum. A translator that takes the wrong bits, or that lets middle bits through, gives port numbers that overlap neighbouring pages. The mode bit is flipped right after every request, which catches a design that reads the mode late and then maps the port or the returned data with the wrong scheme. The 16-bit case checks that the upper half is zeroed and not just left in place. The reserved size code is also exercised, since a design that treats code 3 as 32-bit would scramble bytes the device never asked to have swapped.

// File: rtl/iobr_pkg.sv
package iobr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/iobr_window_map.sv
module iobr_window_map #(
    parameter int unsigned              ADDR_W    = 32,
    parameter int unsigned              PORT_W    = 16,
    parameter int unsigned              WIN_BITS  = 23,
    parameter int unsigned              PAGE_LSB  = 12,
    parameter int unsigned              SPARSE_LO = 5,
    parameter logic [ADDR_W-1:0]        WIN_BASE  = 32'h8000_0000
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sparse_i,
    output logic              hit_o,
    output logic [PORT_W-1:0] port_o
);
    localparam int unsigned PAGE_BITS = WIN_BITS - PAGE_LSB;
    localparam int unsigned SPARSE_W  = PAGE_BITS + SPARSE_LO;

    logic [SPARSE_W-1:0] sparse_raw;
    logic [PORT_W-1:0]   sparse_port;
    logic [PORT_W-1:0]   dense_port;

    // window tag comparison on the bits above the aperture size
    assign hit_o = (addr_i[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);

    // dense: low port-width bits of the offset
    assign dense_port = addr_i[PORT_W-1:0];

    // sparse: page index lands directly above the in-page offset
    assign sparse_raw = {addr_i[WIN_BITS-1:PAGE_LSB], addr_i[SPARSE_LO-1:0]};

    generate
        if (SPARSE_W < PORT_W) begin : g_pad
            assign sparse_port = {{(PORT_W-SPARSE_W){1'b0}}, sparse_raw};
        end else begin : g_fit
            assign sparse_port = sparse_raw[PORT_W-1:0];
        end
    endgenerate

    assign port_o = sparse_i ? sparse_port : dense_port;

endmodule

// File: rtl/iobr_lane_swap.sv
module iobr_lane_swap #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0]     data_i,
    input  iobr_pkg::acc_size_e   size_i,
    output logic [DATA_W-1:0]     data_o
);
    localparam int unsigned BW    = iobr_pkg::BYTE_W;
    localparam int unsigned BYTES = DATA_W / BW;

    logic [DATA_W-1:0] rev_all;
    logic [DATA_W-1:0] rev_half;

    generate
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            assign rev_all[b*BW +: BW] = data_i[(BYTES-1-b)*BW +: BW];
            if (b < 2) begin : g_low
                assign rev_half[b*BW +: BW] = data_i[(1-b)*BW +: BW];
            end else begin : g_high
                assign rev_half[b*BW +: BW] = '0;
            end
        end
    endgenerate

    always_comb begin
        unique case (size_i)
            iobr_pkg::SZ_HALF: data_o = rev_half;
            iobr_pkg::SZ_WORD: data_o = rev_all;
            default:           data_o = data_i;
        endcase
    end

endmodule

// File: rtl/io_window_bridge.sv
module io_window_bridge #(
    parameter int unsigned       ADDR_W    = 32,
    parameter int unsigned       DATA_W    = 32,
    parameter int unsigned       PORT_W    = 16,
    parameter int unsigned       WIN_BITS  = 23,
    parameter int unsigned       PAGE_LSB  = 12,
    parameter int unsigned       SPARSE_LO = 5,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              map_sparse,
    input  logic [DATA_W-1:0] io_rdata,
    output logic              io_rd,
    output logic              io_wr,
    output logic [PORT_W-1:0] io_addr,
    output logic [1:0]        io_size,
    output logic [DATA_W-1:0] io_wdata,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata
);
    import iobr_pkg::*;

    localparam int unsigned TAG_W = ADDR_W - WIN_BITS;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [PORT_W-1:0] port;
        acc_size_e         size;
        logic [DATA_W-1:0] wdata;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } bridge_st_t;

    bridge_st_t st_d, st_q;

    logic              win_hit;
    logic [PORT_W-1:0] mapped_port;
    logic [DATA_W-1:0] wdata_sw;
    logic [DATA_W-1:0] rdata_sw;
    acc_size_e         req_size;

    assign req_size = acc_size_e'(cpu_size);

    iobr_window_map #(
        .ADDR_W    (ADDR_W),
        .PORT_W    (PORT_W),
        .WIN_BITS  (WIN_BITS),
        .PAGE_LSB  (PAGE_LSB),
        .SPARSE_LO (SPARSE_LO),
        .WIN_BASE  (WIN_BASE)
    ) u_map (
        .addr_i   (cpu_addr),
        .sparse_i (map_sparse),
        .hit_o    (win_hit),
        .port_o   (mapped_port)
    );

    // outbound lanes use the size of the incoming request
    iobr_lane_swap #(.DATA_W(DATA_W)) u_wswap (
        .data_i (cpu_wdata),
        .size_i (req_size),
        .data_o (wdata_sw)
    );

    // inbound lanes use the size held for the access on the bus
    iobr_lane_swap #(.DATA_W(DATA_W)) u_rswap (
        .data_i (io_rdata),
        .size_i (st_q.size),
        .data_o (rdata_sw)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rd     = 1'b0;
        st_d.wr     = 1'b0;
        st_d.rvalid = 1'b0;
        if (cpu_req && win_hit) begin
            st_d.rd   = !cpu_we;
            st_d.wr   = cpu_we;
            st_d.port = mapped_port;
            st_d.size = req_size;
            if (cpu_we) begin
                st_d.wdata = wdata_sw;
            end
        end
        if (st_q.rd) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rdata_sw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rd: 1'b0, wr: 1'b0, port: '0, size: SZ_BYTE,
                      wdata: '0, rvalid: 1'b0, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign io_rd      = st_q.rd;
    assign io_wr      = st_q.wr;
    assign io_addr    = st_q.port;
    assign io_size    = st_q.size;
    assign io_wdata   = st_q.wdata;
    assign cpu_rvalid = st_q.rvalid;
    assign cpu_rdata  = st_q.rdata;

    // strobes exclusive and each traced to a request of matching direction
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_wr));
    p_rd_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |-> $past(cpu_req && !cpu_we));
    p_wr_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |-> $past(cpu_req && cpu_we));

    // only in-window requests reach the I/O side
    p_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |-> ($past(cpu_addr[ADDR_W-1:WIN_BITS]) == WIN_BASE[ADDR_W-1:WIN_BITS]));
    p_no_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && (cpu_addr[ADDR_W-1:WIN_BITS] != WIN_BASE[ADDR_W-1:WIN_BITS])) |=> !(io_rd || io_wr));

    // dense mode port equals the low bits of the request address
    p_dense_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd || io_wr) && !$past(map_sparse)) |-> (io_addr == $past(cpu_addr[PORT_W-1:0])));

    // sparse mode keeps the in-page offset in the low port bits
    p_sparse_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd || io_wr) && $past(map_sparse)) |-> (io_addr[SPARSE_LO-1:0] == $past(cpu_addr[SPARSE_LO-1:0])));

    // byte-sized writes arrive untouched
    p_byte_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && (io_size == SZ_BYTE)) |-> (io_wdata == $past(cpu_wdata)));

    // read data valid only right after a read strobe, and only once
    p_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> $past(io_rd));
    p_rd_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> cpu_rvalid);

    // port address held between requests
    p_port_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cpu_req) |-> $stable(io_addr));

    initial begin
        assert (TAG_W > 0) else $error("window must be smaller than address space");
    end

endmodule

// File: tb/io_window_bridge_tb.sv
module io_window_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic        map_sparse = 1'b0;
    logic [31:0] io_rdata;
    logic        io_rd, io_wr, cpu_rvalid;
    logic [15:0] io_addr;
    logic [1:0]  io_size;
    logic [31:0] io_wdata, cpu_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // device model: read data derived from the port number
    function automatic logic [31:0] dev_data(input logic [15:0] p);
        return {p ^ 16'hA5C3, p};
    endfunction

    assign io_rdata = dev_data(io_addr);

    io_window_bridge u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_addr   (cpu_addr),
        .cpu_size   (cpu_size),
        .cpu_we     (cpu_we),
        .cpu_wdata  (cpu_wdata),
        .map_sparse (map_sparse),
        .io_rdata   (io_rdata),
        .io_rd      (io_rd),
        .io_wr      (io_wr),
        .io_addr    (io_addr),
        .io_size    (io_size),
        .io_wdata   (io_wdata),
        .cpu_rvalid (cpu_rvalid),
        .cpu_rdata  (cpu_rdata)
    );

    function automatic logic in_win(input logic [31:0] a);
        return a[31:23] == 9'h100;
    endfunction

    function automatic logic [15:0] exp_port(input logic [31:0] a, input logic sparse);
        return sparse ? {a[22:12], a[4:0]} : a[15:0];
    endfunction

    function automatic logic [31:0] exp_lanes(input logic [31:0] d, input logic [1:0] sz);
        case (sz)
            2'd1:    return {16'h0000, d[7:0], d[15:8]};
            2'd2:    return {d[7:0], d[15:8], d[23:16], d[31:24]};
            default: return d;
        endcase
    endfunction

    function automatic string size_req(input logic [1:0] sz);
        case (sz)
            2'd1:    return "R5";
            2'd2:    return "R6";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one request at a falling edge and check both bus cycles
    task automatic do_access(input logic [31:0] a, input logic [1:0] sz,
                             input logic we, input logic [31:0] wd, input logic mode);
        logic [15:0] ep;
        cpu_addr   = a;
        cpu_size   = sz;
        cpu_we     = we;
        cpu_wdata  = wd;
        map_sparse = mode;
        cpu_req    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cpu_req    = 1'b0;
        map_sparse = ~mode;          // R9: late mode change must not matter
        cpu_addr   = ~a;
        ep = exp_port(a, mode);
        if (!in_win(a)) begin
            chk(!io_rd && !io_wr, "R1", "strobe outside window", {30'd0, io_rd, io_wr}, 32'd0);
        end else begin
            chk(io_rd == !we && io_wr == we, "R7", "strobe kind",
                {30'd0, io_rd, io_wr}, {30'd0, !we, we});
            chk(io_addr == ep, mode ? "R3" : "R2", "port", {16'd0, io_addr}, {16'd0, ep});
            chk(io_size == sz, "R7", "size", {30'd0, io_size}, {30'd0, sz});
            if (we) begin
                chk(io_wdata == exp_lanes(wd, sz), size_req(sz), "write lanes",
                    io_wdata, exp_lanes(wd, sz));
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(!io_rd && !io_wr, "R7", "strobe one cycle", {30'd0, io_rd, io_wr}, 32'd0);
        if (in_win(a) && !we) begin
            chk(cpu_rvalid == 1'b1, "R8", "rvalid", {31'd0, cpu_rvalid}, 32'd1);
            chk(cpu_rdata == exp_lanes(dev_data(ep), sz), size_req(sz), "read lanes R9",
                cpu_rdata, exp_lanes(dev_data(ep), sz));
        end else begin
            chk(cpu_rvalid == 1'b0, in_win(a) ? "R8" : "R1", "no rvalid", {31'd0, cpu_rvalid}, 32'd0);
        end
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(!io_rd && !io_wr && !cpu_rvalid, "R10", "strobes in reset",
            {29'd0, io_rd, io_wr, cpu_rvalid}, 32'd0);
        chk(io_addr == 16'd0 && io_wdata == 32'd0 && cpu_rdata == 32'd0, "R10", "data in reset",
            {16'd0, io_addr} | io_wdata | cpu_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!io_rd && !io_wr && !cpu_rvalid, "R10", "idle after reset",
            {29'd0, io_rd, io_wr, cpu_rvalid}, 32'd0);

        // directed corners: window edges (R1), modes (R2, R3), sizes (R4..R6)
        do_access(32'h8000_0000, 2'd0, 1'b1, 32'h1122_3344, 1'b0);
        do_access(32'h807F_FFFF, 2'd2, 1'b0, 32'h0,         1'b1);
        do_access(32'h7FFF_FFFF, 2'd0, 1'b1, 32'hDEAD_BEEF, 1'b0);
        do_access(32'h8080_0000, 2'd1, 1'b0, 32'h0,         1'b0);
        do_access(32'h0000_0398, 2'd0, 1'b0, 32'h0,         1'b1);
        do_access(32'h807F_FFE0, 2'd1, 1'b1, 32'hCAFE_1234, 1'b1);
        do_access(32'h8001_2FE5, 2'd2, 1'b1, 32'h0102_0304, 1'b1);
        do_access(32'h8000_0092, 2'd3, 1'b1, 32'hA1B2_C3D4, 1'b0);
        do_access(32'h8000_0800, 2'd3, 1'b0, 32'h0,         1'b0);
        do_access(32'h8003_F3F8, 2'd1, 1'b0, 32'h0,         1'b1);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = $urandom();
            if (($urandom() % 4) != 0) a = 32'h8000_0000 | (a & 32'h007F_FFFF);
            do_access(a, 2'($urandom()), 1'($urandom()), $urandom(), 1'($urandom()));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule